// File: doc/BRIEF.md
# Pin interrupt glitch filter

This block watches a group of general-purpose input pins and raises an interrupt when one of them shows a clean edge. Each pin first passes through a synchronizer. Its filter then counts runs of equal samples on the filter clock. An edge is accepted only after the pin has held its idle (passive) level for `RUN_LEN` samples and has then held its active level for `RUN_LEN` samples. Active pulses shorter than that are dropped as glitches. An accepted edge sets a sticky flag for that pin. Software clears the flag by writing a one to its bit. An enabled flag drives the shared interrupt line.

A polarity bit per pin selects which level is active. During stop mode the block also drives a request that keeps the low-power sampling clock running. The request is active only while a pin is still mid-count, its interrupt is enabled and its flag is clear. The clock source itself is outside the block: the same `clk` port carries the bus clock in run and wait mode and the low-power clock in stop mode.

Top module: `pin_irq_filter`

## Requirements
- R1: While reset is low, and after it is released, all flags, enables and polarity bits read 0, and `irq`, `pin_osc_req` and `lp_osc_run` are 0.
- R2: Take a pin with polarity 0, where high is passive and low is active, that has held high for at least 4 samples. If it goes low and stays low, its flag is still 0 after the 5th rising edge at which the pin is low, and is 1 after the 6th (2 synchronizer stages plus 4 samples).
- R3: An active pulse of 1, 2 or 3 clock cycles sets no flag.
- R4: An active pulse of 4 or more clock cycles, preceded by a qualified passive run, sets the pin's flag exactly once.
- R5: A passive run of only 3 samples does not arm the filter, so a following active run of any length sets no flag. After an accepted edge the filter must be armed again before it can accept another.
- R6: Once the passive level is qualified, active excursions of 3 samples or fewer and short returns to passive do not disarm the filter. A later active run of 4 samples sets the flag.
- R7: With polarity 1, low is passive and a high pulse of 4 or more cycles sets the flag.
- R8: A write that changes a pin's polarity bit resets that pin's filter to unarmed, with its count at zero. A qualified passive run seen before the write does not count afterwards.
- R9: Writing 1 to a bit of `flag_clr` clears that flag on the next edge. If a clear and a new accepted edge for the same pin happen on the same edge, the flag stays 1. A set flag with no clear stays 1.
- R10: `irq` is 1 exactly when some pin has both its flag and its enable set.
- R11: `pin_osc_req[i]` is 1 only when `stop_mode` is 1, pin i's run count is at most 4, its enable is 1 and its flag is 0. After 5 or more equal samples the count saturates and the request drops. `lp_osc_run` is the OR of all `pin_osc_req` bits.
- R12: Activity on one pin never changes another pin's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock (bus clock, or the low-power clock in stop mode) |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_mode | input | 1 | 1 while the chip is in stop mode |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pol_we | input | 1 | Write strobe for the polarity register |
| pol_wdata | input | NUM_PINS | New polarity bits (0: active low, 1: active high) |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | NUM_PINS | New interrupt enable bits |
| flag_clr | input | NUM_PINS | Write-one-to-clear strobes for the flags |
| pol_o | output | NUM_PINS | Current polarity bits |
| en_o | output | NUM_PINS | Current enable bits |
| flag_o | output | NUM_PINS | Sticky interrupt flags |
| irq | output | 1 | Interrupt request |
| pin_osc_req | output | NUM_PINS | Per-pin request to keep the low-power clock running |
| lp_osc_run | output | 1 | OR of all per-pin clock requests |

## Verification
A pin change reaches the counters two edges after it is driven. A flag therefore rises on the sixth edge of an active run. `irq` follows the flag in the same cycle, and a clock request rises on the third edge after a change and falls once the count saturates. The bench drives and samples only on falling edges and waits a counted number of cycles before each check. The latency check samples on both sides of the sixth edge. The pulse-width sweep waits long enough that any flag is final, and the clock-request checks sample where the count is known to be 2, or known to be saturated.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    // Filter phase: still looking for a passive run, or armed for an active one
    typedef enum logic {
        PH_SEEK  = 1'b0,
        PH_ARMED = 1'b1
    } phase_e;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage[STAGES-1];
endmodule

// File: rtl/pirq_pin_filter.sv
module pirq_pin_filter
    import pirq_pkg::*;
#(
    parameter int RUN_LEN = 4,
    localparam int CW     = $clog2(RUN_LEN + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_i,
    input  logic          active_lvl_i,
    input  logic          restart_i,
    output logic          fire_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] RUN_CNT = CW'(RUN_LEN);
    localparam logic [CW-1:0] CNT_SAT = CW'(RUN_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          last;
        phase_e        phase;
    } filt_t;

    filt_t st_d, st_q;
    logic  fire_d;
    logic  same_lvl;

    always_comb begin
        st_d     = st_q;
        fire_d   = 1'b0;
        same_lvl = (st_q.cnt != '0) && (sample_i == st_q.last);
        if (restart_i) begin
            st_d.cnt   = '0;
            st_d.last  = sample_i;
            st_d.phase = PH_SEEK;
        end else begin
            st_d.last = sample_i;
            if (same_lvl) begin
                st_d.cnt = (st_q.cnt == CNT_SAT) ? CNT_SAT : st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = CW'(1);
            end
            if (sample_i != active_lvl_i) begin
                if (st_d.cnt == RUN_CNT) st_d.phase = PH_ARMED;
            end else if (st_q.phase == PH_ARMED && st_d.cnt == RUN_CNT) begin
                fire_d     = 1'b1;
                st_d.phase = PH_SEEK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.last  <= 1'b0;
            st_q.phase <= PH_SEEK;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = fire_d;
    assign cnt_o  = st_q.cnt;
endmodule

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pol_we,
    input  logic [NUM_PINS-1:0] pol_wdata,
    input  logic                en_we,
    input  logic [NUM_PINS-1:0] en_wdata,
    input  logic [NUM_PINS-1:0] flag_clr,
    input  logic [NUM_PINS-1:0] fire_i,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] en_o,
    output logic [NUM_PINS-1:0] flag_o,
    output logic [NUM_PINS-1:0] restart_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] pol;
        logic [NUM_PINS-1:0] en;
        logic [NUM_PINS-1:0] flag;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pol_we) st_d.pol = pol_wdata;
        if (en_we)  st_d.en  = en_wdata;
        // a new edge wins over a clear in the same cycle
        st_d.flag = (st_q.flag & ~flag_clr) | fire_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign restart_o = {NUM_PINS{pol_we}} & (pol_wdata ^ st_q.pol);
    assign pol_o     = st_q.pol;
    assign en_o      = st_q.en;
    assign flag_o    = st_q.flag;
endmodule

// File: rtl/pin_irq_filter.sv
module pin_irq_filter #(
    parameter int NUM_PINS    = 8,
    parameter int RUN_LEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_mode,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                pol_we,
    input  logic [NUM_PINS-1:0] pol_wdata,
    input  logic                en_we,
    input  logic [NUM_PINS-1:0] en_wdata,
    input  logic [NUM_PINS-1:0] flag_clr,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] en_o,
    output logic [NUM_PINS-1:0] flag_o,
    output logic                irq,
    output logic [NUM_PINS-1:0] pin_osc_req,
    output logic                lp_osc_run
);
    localparam int CW = $clog2(RUN_LEN + 2);
    localparam logic [CW-1:0] REQ_LIMIT = CW'(RUN_LEN);

    logic [NUM_PINS-1:0] sampled;
    logic [NUM_PINS-1:0] fire;
    logic [NUM_PINS-1:0] restart;
    logic [NUM_PINS-1:0] counting;

    pirq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sampled)
    );

    pirq_cfg_regs #(
        .NUM_PINS (NUM_PINS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pol_we    (pol_we),
        .pol_wdata (pol_wdata),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .flag_clr  (flag_clr),
        .fire_i    (fire),
        .pol_o     (pol_o),
        .en_o      (en_o),
        .flag_o    (flag_o),
        .restart_o (restart)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [CW-1:0] run_cnt;

        pirq_pin_filter #(
            .RUN_LEN (RUN_LEN)
        ) u_filt (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_i     (sampled[i]),
            .active_lvl_i (pol_o[i]),
            .restart_i    (restart[i]),
            .fire_o       (fire[i]),
            .cnt_o        (run_cnt)
        );

        assign counting[i] = (run_cnt <= REQ_LIMIT);
    end

    assign irq         = |(flag_o & en_o);
    assign pin_osc_req = {NUM_PINS{stop_mode}} & counting & en_o & ~flag_o;
    assign lp_osc_run  = stop_mode & |(counting & en_o & ~flag_o);
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stop_mode,
    input logic                pol_we,
    input logic [NUM_PINS-1:0] pol_wdata,
    input logic [NUM_PINS-1:0] pol_o,
    input logic [NUM_PINS-1:0] en_o,
    input logic [NUM_PINS-1:0] flag_o,
    input logic [NUM_PINS-1:0] flag_clr,
    input logic                irq,
    input logic [NUM_PINS-1:0] pin_osc_req,
    input logic                lp_osc_run
);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_o & ~flag_clr)) |=>
            ((flag_o & $past(flag_o & ~flag_clr)) == $past(flag_o & ~flag_clr)));

    // R10
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(en_o & flag_o)));

    // R11
    osc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |-> (!lp_osc_run && pin_osc_req == '0));

    // R11
    osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_osc_req & (flag_o | ~en_o)) == '0);

    // R11
    osc_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_osc_run == (|pin_osc_req));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
        // R8
        pol_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pol_we && (pol_wdata[i] != pol_o[i])) |=>
                !$rose(flag_o[i]) ##1 !$rose(flag_o[i]));
    end
endmodule

bind pin_irq_filter pirq_chk #(.NUM_PINS(NUM_PINS)) u_pirq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_mode   (stop_mode),
    .pol_we      (pol_we),
    .pol_wdata   (pol_wdata),
    .pol_o       (pol_o),
    .en_o        (en_o),
    .flag_o      (flag_o),
    .flag_clr    (flag_clr),
    .irq         (irq),
    .pin_osc_req (pin_osc_req),
    .lp_osc_run  (lp_osc_run)
);

// File: tb/tb_pin_irq_filter.sv
`timescale 1ns/1ps
module tb_pin_irq_filter;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          stop_mode;
    logic [NP-1:0] pin_in;
    logic          pol_we;
    logic [NP-1:0] pol_wdata;
    logic          en_we;
    logic [NP-1:0] en_wdata;
    logic [NP-1:0] flag_clr;
    logic [NP-1:0] pol_o, en_o, flag_o, pin_osc_req;
    logic          irq, lp_osc_run;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pin_irq_filter #(.NUM_PINS(NP), .RUN_LEN(4), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .pin_in(pin_in),
        .pol_we(pol_we), .pol_wdata(pol_wdata), .en_we(en_we), .en_wdata(en_wdata),
        .flag_clr(flag_clr), .pol_o(pol_o), .en_o(en_o), .flag_o(flag_o),
        .irq(irq), .pin_osc_req(pin_osc_req), .lp_osc_run(lp_osc_run)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        flag_clr = '1;
        cyc(1);
        flag_clr = '0;
    endtask

    task automatic set_en(input logic [NP-1:0] v);
        en_we = 1'b1; en_wdata = v;
        cyc(1);
        en_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stop_mode = 1'b0; pin_in = '1;
        pol_we = 1'b0; pol_wdata = '0; en_we = 1'b0; en_wdata = '0; flag_clr = '0;
        cyc(3);
        // R1 during reset
        chk("R1 regs in reset", {pol_o, en_o, flag_o}, '0);
        chk("R1 outs in reset", {irq, lp_osc_run, pin_osc_req}, '0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 after reset", {pol_o, en_o, flag_o, irq, lp_osc_run, pin_osc_req}, '0);

        set_en('1);
        cyc(8);

        // R2 latency on pin 0, polarity 0
        pin_in[0] = 1'b0;
        cyc(5);
        chk("R2 flag before 6th edge", flag_o, 2'b00);
        cyc(1);
        chk("R2 flag at 6th edge", flag_o, 2'b01);
        chk("R10 irq with enabled flag", irq, 1'b1);
        pin_in[0] = 1'b1;
        cyc(8);

        // R9 plain clear
        flag_clr = 2'b01;
        cyc(1);
        flag_clr = '0;
        chk("R9 clear", flag_o, 2'b00);

        // R9 clear in the same cycle as a new edge
        pin_in[0] = 1'b0; cyc(6); pin_in[0] = 1'b1; cyc(8);
        chk("R9 flag set before collision", flag_o, 2'b01);
        pin_in[0] = 1'b0;
        cyc(5);
        flag_clr = 2'b01;
        cyc(1);
        flag_clr = '0;
        chk("R9 edge wins over clear", flag_o, 2'b01);
        pin_in[0] = 1'b1; cyc(8);
        clear_all();

        // R3 R4 R7 R12 pulse-width sweep
        for (int pv = 0; pv < 2; pv++) begin
            pol_we = 1'b1; pol_wdata = {NP{pv[0]}};
            pin_in = {NP{~pv[0]}};
            cyc(1);
            pol_we = 1'b0;
            cyc(8);
            clear_all();
            for (int p = 0; p < NP; p++) begin
                for (int w = 1; w <= 7; w++) begin
                    logic [NP-1:0] exp_v;
                    string tag;
                    exp_v = (w >= 4) ? NP'(1 << p) : '0;
                    tag = (w >= 4) ? "R4" : "R3";
                    if (pv == 1) tag = {tag, " R7"};
                    pin_in[p] = pv[0];
                    cyc(w);
                    pin_in[p] = ~pv[0];
                    cyc(8);
                    chk({tag, " R12 flag after pulse"}, flag_o, exp_v);
                    chk("R10 irq after pulse", irq, exp_v != '0);
                    clear_all();
                end
            end
        end

        // back to polarity 0, pins high
        pol_we = 1'b1; pol_wdata = '0; pin_in = '1;
        cyc(1);
        pol_we = 1'b0;
        cyc(8);
        clear_all();

        // R5 short passive run does not arm
        pin_in[0] = 1'b0; cyc(6);
        chk("R5 first edge accepted", flag_o, 2'b01);
        clear_all();
        pin_in[0] = 1'b1; cyc(3);
        pin_in[0] = 1'b0; cyc(8);
        chk("R5 three passive samples not enough", flag_o, 2'b00);
        pin_in[0] = 1'b1; cyc(8);

        // R6 indirect path after qualification
        pin_in[0] = 1'b0; cyc(2);
        pin_in[0] = 1'b1; cyc(1);
        pin_in[0] = 1'b0; cyc(3);
        pin_in[0] = 1'b1; cyc(2);
        cyc(3);
        chk("R6 excursions set nothing", flag_o, 2'b00);
        pin_in[0] = 1'b0; cyc(4);
        pin_in[0] = 1'b1; cyc(8);
        chk("R6 armed state survived excursions", flag_o, 2'b01);
        clear_all();

        // R8 polarity change drops qualification
        cyc(4);
        pol_we = 1'b1; pol_wdata = 2'b01;
        cyc(1);
        pol_wdata = 2'b00; pin_in[0] = 1'b0;
        cyc(1);
        pol_we = 1'b0;
        cyc(7);
        chk("R8 restart after polarity change", flag_o, 2'b00);
        pin_in[0] = 1'b1; cyc(8);
        pin_in[0] = 1'b0; cyc(6); pin_in[0] = 1'b1; cyc(8);
        chk("R8 filter works after restart", flag_o, 2'b01);
        clear_all();

        // R10 enable gates irq
        set_en(2'b10);
        pin_in[0] = 1'b0; cyc(6); pin_in[0] = 1'b1; cyc(8);
        chk("R10 flag set while disabled", flag_o, 2'b01);
        chk("R10 irq masked", irq, 1'b0);
        set_en(2'b11);
        chk("R10 irq after enable", irq, 1'b1);
        clear_all();

        // R11 clock request
        stop_mode = 1'b1;
        cyc(10);
        chk("R11 saturated count drops request", {lp_osc_run, pin_osc_req}, 3'b000);
        pin_in[1] = 1'b0;
        cyc(4);
        chk("R11 request while counting", {lp_osc_run, pin_osc_req}, 3'b110);
        cyc(3);
        chk("R11 request drops with flag", {lp_osc_run, pin_osc_req}, 3'b000);
        clear_all();
        chk("R11 flag cleared", flag_o, 2'b00);
        pin_in[1] = 1'b1;
        en_we = 1'b1; en_wdata = 2'b01;
        cyc(1);
        en_we = 1'b0;
        cyc(3);
        chk("R11 disabled pin makes no request", {lp_osc_run, pin_osc_req}, 3'b000);
        set_en(2'b11);
        stop_mode = 1'b0;
        pin_in[1] = 1'b0;
        cyc(3);
        chk("R11 no request outside stop mode", {lp_osc_run, pin_osc_req}, 3'b000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule